// File: doc/BRIEF.md
# Early-Terminating SAD Block Matcher

This block scores a stream of candidate blocks against a current block and keeps the best one. The score is the sum of absolute differences (SAD) between corresponding 8-bit pixels. Each clock cycle the block can take one row of pixel pairs: a row of the current block and the matching row of the candidate. A start marker and an end marker frame each candidate. The end-marker row also carries the candidate's signed displacement and a flag that says whether this candidate is the last one in the search.

Each candidate's running sum is compared with the best complete SAD seen so far in the search. Once the running sum reaches or passes that best value, the candidate is abandoned for its remaining rows. While a candidate is abandoned, the inputs of the absolute-difference units are frozen at their last used values, so the adders do no more work. Rows are still accepted at the full rate, so early termination saves switching activity but does not save cycles.

When the last candidate's end row has been taken, a one-cycle done pulse reports that the minimum SAD and its displacement are final. A search-start pulse opens a new search.

Top module: `sad_match_engine`

## Requirements
- R1: The cost of a candidate is the sum, over every accepted row from its start-marker row to its end-marker row, of |cur - cand| for each pixel pair. Pixel column c occupies bits [8c+7:8c] of `curRow` and `candRow`.
- R2: After a row that is not an end-marker row is accepted, `earlyStop` is 1 if the candidate's running sum after any of its rows so far is greater than or equal to `bestSad`. `earlyStop` returns to 0 in the cycle after the end-marker row is accepted.
- R3: While a candidate is stopped, the operands of the absolute-difference units stay at their last used values, and the candidate's later rows cannot change `bestSad`, `bestMvX` or `bestMvY`.
- R4: At done, `bestSad` equals the minimum cost over all candidates of the search, exactly as an exhaustive comparison without early stopping would give.
- R5: `rowReady` is 1 in every cycle from the first cycle after reset. Every row presented with `rowValid` high is accepted in that same cycle.
- R6: A `searchStart` pulse sets `bestSad` to 16383 (all ones) and both displacement outputs to 0. As a result, the first candidate of a search never raises `earlyStop`.
- R7: When a candidate's cost equals the current best, the earlier candidate's cost and displacement are kept.
- R8: `candMvX` and `candMvY` are signed 6-bit values sampled on the end-marker row. They appear on `bestMvX` and `bestMvY` when that candidate becomes the best.
- R9: `done` is high for exactly one cycle, in the cycle after the end-marker row that has `lastCand` high. `bestSad` and the displacement outputs then stay unchanged until the next `searchStart`.
- R10: During and right after reset, `done` and `earlyStop` are 0, `bestSad` is all ones and both displacement outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| searchStart | input | 1 | Opens a new search and resets the best result |
| rowValid | input | 1 | A pixel row pair is presented |
| rowReady | output | 1 | Row is accepted (high in every cycle after reset) |
| candFirst | input | 1 | Marks the first row of a candidate |
| candLast | input | 1 | Marks the last row of a candidate |
| lastCand | input | 1 | With candLast, marks the final candidate of the search |
| curRow | input | 64 | Eight current-block pixels |
| candRow | input | 64 | Eight candidate-block pixels |
| candMvX | input | 6 | Signed horizontal displacement, sampled on the end row |
| candMvY | input | 6 | Signed vertical displacement, sampled on the end row |
| bestSad | output | 14 | Lowest complete SAD so far |
| bestMvX | output | 6 | Horizontal displacement of the best candidate |
| bestMvY | output | 6 | Vertical displacement of the best candidate |
| earlyStop | output | 1 | The current candidate has been abandoned |
| done | output | 1 | One-cycle pulse: the search result is final |

## Verification
The bench builds the engine with its default parameters: 8 columns of 8-bit pixels, a 14-bit sum and 6-bit displacements. The worst-case cost of 16320 then sits just below the all-ones start value, so both the saturation margin and the rule that the first candidate always completes are within reach.

A sweep of several dozen searches covers the rest. Each search has one to six candidates, with noise amplitudes ranging from zero to full scale, repeated candidates that force ties, and idle gaps between rows. This makes stopping happen on every row position, never happen, or happen at once on zero-cost matches. After each row the bench compares the result with an exhaustive minimum and a row-by-row stop model.

// File: rtl/sad_match_pkg.sv
package sad_match_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic load;       // accepted row goes through the PEs
    logic first;      // row is the first of a candidate
    logic endCand;    // accepted end row of a live candidate
    logic newSearch;  // reset best result
    logic gated;      // accepted row of a stopped candidate
  } sadStrobe_t;
endpackage

// File: rtl/sad_match_datapath.sv
module sad_match_datapath
  import sad_match_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int COLS  = 8,
  parameter int SAD_W = 14,
  parameter int MV_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  sadStrobe_t              stb,
  input  logic [COLS*PIX_W-1:0]   curRow,
  input  logic [COLS*PIX_W-1:0]   candRow,
  input  logic signed [MV_W-1:0]  mvXIn,
  input  logic signed [MV_W-1:0]  mvYIn,
  output logic                    reachBest,
  output logic [SAD_W-1:0]        bestSad,
  output logic signed [MV_W-1:0]  bestMvX,
  output logic signed [MV_W-1:0]  bestMvY
);
  localparam int ROW_W   = COLS * PIX_W;
  localparam int ROWSUM_W = PIX_W + $clog2(COLS);

  logic [ROW_W-1:0]    heldCur, heldCand, peCur, peCand;
  logic [PIX_W-1:0]    diffs [COLS];
  logic [ROWSUM_W-1:0] rowSum;
  logic [SAD_W-1:0]    accQ, sumNext, bestQ;
  logic signed [MV_W-1:0] mvXQ, mvYQ;

  // Operand masking: a stopped candidate leaves the PE inputs frozen
  assign peCur  = stb.load ? curRow  : heldCur;
  assign peCand = stb.load ? candRow : heldCand;

  for (genvar c = 0; c < COLS; c++) begin : g_pe
    logic [PIX_W-1:0] pa, pb;
    assign pa = peCur[c*PIX_W +: PIX_W];
    assign pb = peCand[c*PIX_W +: PIX_W];
    assign diffs[c] = (pa > pb) ? (pa - pb) : (pb - pa);
  end

  always_comb begin
    rowSum = '0;
    for (int c = 0; c < COLS; c++) rowSum = rowSum + ROWSUM_W'(diffs[c]);
  end

  assign sumNext   = (stb.first ? '0 : accQ) + {{(SAD_W-ROWSUM_W){1'b0}}, rowSum};
  assign reachBest = (sumNext >= bestQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldCur  <= '0;
      heldCand <= '0;
      accQ     <= '0;
      bestQ    <= '1;
      mvXQ     <= '0;
      mvYQ     <= '0;
    end else begin
      if (stb.load) begin
        heldCur  <= peCur;
        heldCand <= peCand;
        accQ     <= sumNext;
      end
      if (stb.newSearch) begin
        bestQ <= '1;
        mvXQ  <= '0;
        mvYQ  <= '0;
      end else if (stb.endCand && (sumNext < bestQ)) begin
        bestQ <= sumNext;
        mvXQ  <= mvXIn;
        mvYQ  <= mvYIn;
      end
    end
  end

  assign bestSad = bestQ;
  assign bestMvX = mvXQ;
  assign bestMvY = mvYQ;

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.load && $past(!stb.load)) |-> ($stable(peCur) && $stable(peCand)));
  // R6
  first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.gated |-> (bestQ != '1));
  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.newSearch |=> (bestQ <= $past(bestQ)));
  // R9
  best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.newSearch && !stb.endCand) |=> ($stable(bestQ) && $stable(mvXQ) && $stable(mvYQ)));
endmodule

// File: rtl/sad_match_ctrl.sv
module sad_match_ctrl
  import sad_match_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       searchStart,
  input  logic       rowValid,
  input  logic       candFirst,
  input  logic       candLast,
  input  logic       lastCand,
  input  logic       reachBest,
  output logic       rowReady,
  output sadStrobe_t stb,
  output logic       earlyStop,
  output logic       done
);
  logic readyQ, stopQ, doneQ, accept, gateEff;

  assign accept  = rowValid && readyQ;
  assign gateEff = stopQ && !candFirst;

  always_comb begin
    stb.load      = accept && !gateEff;
    stb.first     = candFirst;
    stb.endCand   = accept && !gateEff && candLast;
    stb.newSearch = searchStart;
    stb.gated     = accept && gateEff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyQ <= 1'b0;
      stopQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      doneQ  <= accept && candLast && lastCand;
      if (searchStart)  stopQ <= 1'b0;
      else if (accept)  stopQ <= candLast ? 1'b0 : (gateEff || reachBest);
    end
  end

  assign rowReady  = readyQ;
  assign earlyStop = stopQ;
  assign done      = doneQ;

  // R2
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && candLast) |=> !earlyStop);
  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rowReady |=> rowReady);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(accept && candLast && lastCand)) |=> !done);
  // R2
  stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (earlyStop && !candLast && !searchStart && !candFirst) |=> earlyStop);
endmodule

// File: rtl/sad_match_engine.sv
module sad_match_engine
  import sad_match_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int COLS  = 8,
  parameter int SAD_W = 14,
  parameter int MV_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    searchStart,
  input  logic                    rowValid,
  output logic                    rowReady,
  input  logic                    candFirst,
  input  logic                    candLast,
  input  logic                    lastCand,
  input  logic [COLS*PIX_W-1:0]   curRow,
  input  logic [COLS*PIX_W-1:0]   candRow,
  input  logic signed [MV_W-1:0]  candMvX,
  input  logic signed [MV_W-1:0]  candMvY,
  output logic [SAD_W-1:0]        bestSad,
  output logic signed [MV_W-1:0]  bestMvX,
  output logic signed [MV_W-1:0]  bestMvY,
  output logic                    earlyStop,
  output logic                    done
);
  sadStrobe_t stb;
  logic       reachBest;

  sad_match_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .searchStart(searchStart), .rowValid(rowValid),
    .candFirst(candFirst), .candLast(candLast), .lastCand(lastCand),
    .reachBest(reachBest), .rowReady(rowReady), .stb(stb),
    .earlyStop(earlyStop), .done(done)
  );

  sad_match_datapath #(.PIX_W(PIX_W), .COLS(COLS), .SAD_W(SAD_W), .MV_W(MV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .curRow(curRow), .candRow(candRow),
    .mvXIn(candMvX), .mvYIn(candMvY), .reachBest(reachBest),
    .bestSad(bestSad), .bestMvX(bestMvX), .bestMvY(bestMvY)
  );
endmodule

// File: tb/sad_match_engine_tb.sv
module sad_match_engine_tb;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int ALL1 = 16383;

  logic clk = 0, rst_n = 0;
  logic searchStart = 0, rowValid = 0, candFirst = 0, candLast = 0, lastCand = 0;
  logic [63:0] curRow = '0, candRow = '0;
  logic signed [5:0] candMvX = '0, candMvY = '0;
  logic rowReady, earlyStop, done;
  logic [13:0] bestSad;
  logic signed [5:0] bestMvX, bestMvY;

  int checks = 0, errors = 0;
  int curPix [ROWS][COLS];
  int candPix [ROWS][COLS];
  int lcg = 12345;
  int expBest, expMvX, expMvY, refBest;
  bit finished = 0;

  always #10 clk = ~clk;

  sad_match_engine u_dut (
    .clk(clk), .rst_n(rst_n), .searchStart(searchStart), .rowValid(rowValid),
    .rowReady(rowReady), .candFirst(candFirst), .candLast(candLast), .lastCand(lastCand),
    .curRow(curRow), .candRow(candRow), .candMvX(candMvX), .candMvY(candMvY),
    .bestSad(bestSad), .bestMvX(bestMvX), .bestMvY(bestMvY),
    .earlyStop(earlyStop), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  function automatic logic [63:0] packRow(input bit useCand, input int r);
    logic [63:0] v;
    for (int c = 0; c < COLS; c++)
      v[c*8 +: 8] = 8'(useCand ? candPix[r][c] : curPix[r][c]);
    return v;
  endfunction

  task automatic startSearch();
    @(negedge clk);
    searchStart = 1;
    @(negedge clk);
    searchStart = 0;
    chk(bestSad == 14'(ALL1), "R6", "bestSad after start", bestSad, ALL1);
    chk(bestMvX == 0 && bestMvY == 0, "R6", "mv after start", bestMvX, 0);
    expBest = ALL1; refBest = ALL1; expMvX = 0; expMvY = 0;
  endtask

  // Sends one candidate from candPix, checks per-row stop flag against a model
  task automatic runCand(input int mvx, input int mvy, input bit lastC, input bit isFirstCand, input bit gaps);
    int partial = 0;
    bit stopped = 0;
    int prevBest = expBest;
    for (int r = 0; r < ROWS; r++) begin
      int rs = 0;
      for (int c = 0; c < COLS; c++) begin
        int d = curPix[r][c] - candPix[r][c];
        rs += (d < 0) ? -d : d;
      end
      partial += rs;
      if (gaps && (rnd() % 4 == 0)) @(negedge clk);
      rowValid = 1; candFirst = (r == 0); candLast = (r == ROWS-1);
      lastCand = lastC && (r == ROWS-1);
      curRow = packRow(0, r); candRow = packRow(1, r);
      candMvX = 6'(mvx); candMvY = 6'(mvy);
      chk(rowReady == 1, "R5", "rowReady while presenting", rowReady, 1);
      @(negedge clk);
      rowValid = 0; candFirst = 0; candLast = 0; lastCand = 0;
      if (r < ROWS-1) stopped = stopped || (partial >= prevBest);
      if (r < ROWS-1) begin
        chk(earlyStop == stopped, "R2", "earlyStop after row", earlyStop, stopped);
        if (isFirstCand) chk(earlyStop == 0, "R6", "first candidate never stops", earlyStop, 0);
      end else begin
        chk(earlyStop == 0, "R2", "earlyStop cleared after end row", earlyStop, 0);
        chk(done == lastC, "R9", "done one cycle after final end row", done, lastC);
      end
    end
    if (!stopped && partial < expBest) begin
      expBest = partial; expMvX = mvx; expMvY = mvy;
    end
    if (partial < refBest) refBest = partial;
    chk(bestSad == 14'(expBest), stopped ? "R3" : "R1", "bestSad after candidate", bestSad, expBest);
    chk(bestMvX == 6'(expMvX) && bestMvY == 6'(expMvY), "R8", "best displacement",
        int'(bestMvX), expMvX);
  endtask

  task automatic finishSearch();
    chk(bestSad == 14'(refBest), "R4", "equals exhaustive minimum", bestSad, refBest);
    @(negedge clk);
    chk(done == 0, "R9", "done lasts one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(bestSad == 14'(expBest) && bestMvX == 6'(expMvX), "R9", "result held", bestSad, expBest);
  endtask

  task automatic genCand(input int amp);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int v = curPix[r][c] + (rnd() % (2*amp + 1)) - amp;
        candPix[r][c] = (v < 0) ? 0 : (v > 255 ? 255 : v);
      end
  endtask

  initial begin
    int amps [6] = '{0, 2, 10, 40, 128, 255};
    repeat (3) @(negedge clk);
    chk(done == 0 && earlyStop == 0, "R10", "flags in reset", done, 0);
    chk(bestSad == 14'(ALL1), "R10", "bestSad in reset", bestSad, ALL1);
    chk(bestMvX == 0 && bestMvY == 0, "R10", "mv in reset", bestMvX, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rowReady == 1, "R5", "rowReady after reset", rowReady, 1);

    // Worst case, then an equal-cost candidate: tie keeps the earlier one
    startSearch();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin curPix[r][c] = 0; candPix[r][c] = 255; end
    runCand(-32, 31, 0, 1, 0);
    chk(bestSad == 14'd16320, "R6", "full-scale first candidate completes", bestSad, 16320);
    runCand(5, -5, 1, 0, 0);
    chk(bestMvX == -6'sd32 && bestMvY == 6'sd31, "R7", "tie keeps earlier", int'(bestMvX), -32);
    finishSearch();

    // Sweep of searches
    for (int s = 0; s < 60; s++) begin
      int nCand = 1 + (s % 6);
      bit tieMode = (s % 5 == 2);
      startSearch();
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) curPix[r][c] = rnd() % 256;
      for (int k = 0; k < nCand; k++) begin
        int saveLcg;
        int mvx = ((k*13 + s) % 64) - 32;
        int mvy = ((k*5 + 2*s) % 64) - 32;
        if (tieMode && k > 0 && k % 2 == 1) begin
          saveLcg = lcg; lcg = 777 + s; genCand(amps[(s+k-1) % 6]); lcg = saveLcg;
        end else if (tieMode) begin
          saveLcg = lcg; lcg = 777 + s; genCand(amps[(s+k) % 6]); lcg = saveLcg;
        end else begin
          genCand(amps[(s*7 + k*3) % 6]);
        end
        runCand(mvx, mvy, k == nCand-1, k == 0, s % 3 == 1);
      end
      finishSearch();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule